// File: doc/BRIEF.md
# Instruction Decode and Next-PC Stage

This stage takes a fixed-length 32-bit instruction word together with the address it was fetched from and a branch outcome bit. It then produces the decoded fields of that instruction, a class flag naming the operation, and the address of the following instruction. Three encodings share the word. A register form carries three 5-bit register numbers, an extended operation code and a 5-bit shift amount. An immediate form carries two register numbers and a 16-bit constant. A jump form carries a 26-bit target field. The 6-bit primary operation code always sits in the low bits.

The decoder recognises addition, subtraction, addition of an immediate, a signed less-than branch, a word load and a subroutine call. Every other code is reported as illegal. The next address is one of three values. Normally it is the current address plus 4. A taken branch adds the sign-extended 16-bit byte displacement to that sequential address. A call keeps the top four bits of the current address and fills the rest with the 26-bit field shifted left by two.

All outputs come from registers. The results for inputs sampled at one rising clock edge appear right after that edge. The register file and the execution units are not part of this block.

Top module: `decode_stage`

## Requirements
- R1: While rst_n is low, every output is zero. This includes all class flags, illegal and next_pc.
- R2: After the rising edge that samples instr, the field outputs hold these bit slices of the sampled word: reg_a = [31:27], reg_b = [26:22], reg_c = [21:17], ext_op = [16:11], shamt = [10:6], opcode = [5:0], imm16 = [21:6] and imm26 = [31:6].
- R3: imm16_sx holds imm16 sign-extended to 32 bits, which means bit 15 is copied into bits 31:16.
- R4: Opcode 0x3A selects the register form. Within that form, ext_op 0x31 raises is_add and ext_op 0x39 raises is_sub.
- R5: Opcode 0x04 raises is_addi, 0x16 raises is_blt, 0x17 raises is_ldw and 0x00 raises is_call.
- R6: Any other opcode, or opcode 0x3A with any other ext_op, raises illegal with all class flags low. Exactly one of the seven flags is high for each decoded word.
- R7: For every word that is not a call and not a taken blt, next_pc = pc + 4 modulo 2^32. This includes illegal words and a blt with br_taken low.
- R8: For blt with br_taken high, next_pc = pc + 4 + sign-extended imm16, wrapping modulo 2^32.
- R9: For call, next_pc = {pc[31:28], imm26, 2'b00}.
- R10: br_taken has no effect on any output unless the word is blt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction, word aligned |
| br_taken | input | 1 | Branch condition result for this word |
| reg_a | output | 5 | Register field A |
| reg_b | output | 5 | Register field B |
| reg_c | output | 5 | Register field C (register form) |
| ext_op | output | 6 | Extended operation code |
| shamt | output | 5 | 5-bit immediate |
| opcode | output | 6 | Primary operation code |
| imm16 | output | 16 | 16-bit immediate |
| imm16_sx | output | 32 | Sign-extended 16-bit immediate |
| imm26 | output | 26 | 26-bit jump field |
| is_add | output | 1 | Register-form add |
| is_sub | output | 1 | Register-form subtract |
| is_addi | output | 1 | Add immediate |
| is_blt | output | 1 | Signed less-than branch |
| is_ldw | output | 1 | Word load |
| is_call | output | 1 | Subroutine call |
| illegal | output | 1 | Unrecognised encoding |
| next_pc | output | 32 | Address of the following instruction |

## Verification
The stage has exactly one register level, so any fault becomes visible at the ports one clock after the word that exposes it. No faulty state can hide and surface later. A misplaced slice shows up as a field that disagrees with the bench's own bit extraction. A wrong operation-code constant shows up as a flag on the wrong class, or as illegal on a listed code. Broken displacement arithmetic appears as a next_pc that is off by a sign or carry, and is most exposed by negative displacements and by addresses near the top of the space.

// File: rtl/decode_pkg.sv
package decode_pkg;

  parameter int unsigned XLEN   = 32;
  parameter int unsigned REG_W  = 5;
  parameter int unsigned OP_W   = 6;
  parameter int unsigned IMM_W  = 16;
  parameter int unsigned SH_W   = 5;
  parameter int unsigned JMP_W  = 26;
  parameter int unsigned INSN_B = 4;

  localparam int unsigned REGION_W = XLEN - JMP_W - 2;

  localparam logic [OP_W-1:0] OPC_RFORM = 6'h3A;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'h04;
  localparam logic [OP_W-1:0] OPC_BLT   = 6'h16;
  localparam logic [OP_W-1:0] OPC_LDW   = 6'h17;
  localparam logic [OP_W-1:0] OPC_CALL  = 6'h00;
  localparam logic [OP_W-1:0] XOP_ADD   = 6'h31;
  localparam logic [OP_W-1:0] XOP_SUB   = 6'h39;

  typedef struct packed {
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic [REG_W-1:0] rc;
    logic [OP_W-1:0]  xop;
    logic [SH_W-1:0]  sh;
    logic [OP_W-1:0]  op;
    logic [IMM_W-1:0] i16;
    logic [JMP_W-1:0] i26;
  } fields_t;

  typedef struct packed {
    logic add;
    logic sub;
    logic addi;
    logic blt;
    logic ldw;
    logic call;
    logic bad;
  } kind_t;

  typedef enum logic [1:0] {
    NPC_SEQ,
    NPC_BR,
    NPC_JMP
  } npc_sel_e;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] seq_addr(input logic [XLEN-1:0] a);
    return a + XLEN'(INSN_B);
  endfunction

  function automatic logic [XLEN-1:0] branch_addr(input logic [XLEN-1:0] a,
                                                  input logic [IMM_W-1:0] d);
    return seq_addr(a) + sext_imm(d);
  endfunction

  function automatic logic [XLEN-1:0] jump_addr(input logic [XLEN-1:0] a,
                                                input logic [JMP_W-1:0] t);
    return {a[XLEN-1 -: REGION_W], t, 2'b00};
  endfunction

endpackage

// File: rtl/decode_fields.sv
module decode_fields
  import decode_pkg::*;
(
  input  logic [XLEN-1:0] word,
  output fields_t         fld
);

  localparam int unsigned RA_LSB  = XLEN - REG_W;
  localparam int unsigned RB_LSB  = RA_LSB - REG_W;
  localparam int unsigned RC_LSB  = RB_LSB - REG_W;
  localparam int unsigned XOP_LSB = RC_LSB - OP_W;
  localparam int unsigned SH_LSB  = XOP_LSB - SH_W;

  always_comb begin
    fld.ra  = word[RA_LSB  +: REG_W];
    fld.rb  = word[RB_LSB  +: REG_W];
    fld.rc  = word[RC_LSB  +: REG_W];
    fld.xop = word[XOP_LSB +: OP_W];
    fld.sh  = word[SH_LSB  +: SH_W];
    fld.op  = word[0       +: OP_W];
    fld.i16 = word[OP_W    +: IMM_W];
    fld.i26 = word[OP_W    +: JMP_W];
  end

endmodule

// File: rtl/decode_class.sv
module decode_class
  import decode_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [OP_W-1:0] xop,
  output kind_t           kind
);

  logic rform;
  assign rform = (op == OPC_RFORM);

  always_comb begin
    kind      = '0;
    kind.add  = rform && (xop == XOP_ADD);
    kind.sub  = rform && (xop == XOP_SUB);
    kind.addi = (op == OPC_ADDI);
    kind.blt  = (op == OPC_BLT);
    kind.ldw  = (op == OPC_LDW);
    kind.call = (op == OPC_CALL);
    kind.bad  = !(kind.add || kind.sub || kind.addi ||
                  kind.blt || kind.ldw || kind.call);
  end

endmodule

// File: rtl/decode_nextpc.sv
module decode_nextpc
  import decode_pkg::*;
(
  input  logic [XLEN-1:0]  cur_pc,
  input  logic             is_br,
  input  logic             is_jmp,
  input  logic             taken,
  input  logic [IMM_W-1:0] disp,
  input  logic [JMP_W-1:0] tgt,
  output npc_sel_e         sel,
  output logic [XLEN-1:0]  npc
);

  logic [XLEN-1:0] a_seq, a_br, a_jmp;

  assign a_seq = seq_addr(cur_pc);
  assign a_br  = branch_addr(cur_pc, disp);
  assign a_jmp = jump_addr(cur_pc, tgt);

  always_comb begin
    if (is_jmp)              sel = NPC_JMP;
    else if (is_br && taken) sel = NPC_BR;
    else                     sel = NPC_SEQ;
  end

  always_comb begin
    unique case (sel)
      NPC_BR:  npc = a_br;
      NPC_JMP: npc = a_jmp;
      default: npc = a_seq;
    endcase
  end

endmodule

// File: rtl/decode_stage.sv
module decode_stage
  import decode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [XLEN-1:0]      instr,
  input  logic [XLEN-1:0]      pc,
  input  logic                 br_taken,
  output logic [REG_W-1:0]     reg_a,
  output logic [REG_W-1:0]     reg_b,
  output logic [REG_W-1:0]     reg_c,
  output logic [OP_W-1:0]      ext_op,
  output logic [SH_W-1:0]      shamt,
  output logic [OP_W-1:0]      opcode,
  output logic [IMM_W-1:0]     imm16,
  output logic [XLEN-1:0]      imm16_sx,
  output logic [JMP_W-1:0]     imm26,
  output logic                 is_add,
  output logic                 is_sub,
  output logic                 is_addi,
  output logic                 is_blt,
  output logic                 is_ldw,
  output logic                 is_call,
  output logic                 illegal,
  output logic [XLEN-1:0]      next_pc
);

  fields_t         d_fld,  q_fld;
  kind_t           d_kind, q_kind;
  npc_sel_e        d_sel;
  logic [XLEN-1:0] d_npc,  q_npc;
  logic [XLEN-1:0] d_sx,   q_sx;

  decode_fields u_fields (
    .word (instr),
    .fld  (d_fld)
  );

  decode_class u_class (
    .op   (d_fld.op),
    .xop  (d_fld.xop),
    .kind (d_kind)
  );

  decode_nextpc u_npc (
    .cur_pc (pc),
    .is_br  (d_kind.blt),
    .is_jmp (d_kind.call),
    .taken  (br_taken),
    .disp   (d_fld.i16),
    .tgt    (d_fld.i26),
    .sel    (d_sel),
    .npc    (d_npc)
  );

  assign d_sx = sext_imm(d_fld.i16);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_fld  <= '0;
      q_kind <= '0;
      q_npc  <= '0;
      q_sx   <= '0;
    end else begin
      q_fld  <= d_fld;
      q_kind <= d_kind;
      q_npc  <= d_npc;
      q_sx   <= d_sx;
    end
  end

  assign reg_a    = q_fld.ra;
  assign reg_b    = q_fld.rb;
  assign reg_c    = q_fld.rc;
  assign ext_op   = q_fld.xop;
  assign shamt    = q_fld.sh;
  assign opcode   = q_fld.op;
  assign imm16    = q_fld.i16;
  assign imm26    = q_fld.i26;
  assign imm16_sx = q_sx;
  assign is_add   = q_kind.add;
  assign is_sub   = q_kind.sub;
  assign is_addi  = q_kind.addi;
  assign is_blt   = q_kind.blt;
  assign is_ldw   = q_kind.ldw;
  assign is_call  = q_kind.call;
  assign illegal  = q_kind.bad;
  assign next_pc  = q_npc;

  logic unused_sel;
  assign unused_sel = ^d_sel;

endmodule

// File: rtl/decode_stage_chk.sv
module decode_stage_chk
  import decode_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [XLEN-1:0]  instr,
  input logic [XLEN-1:0]  pc,
  input logic             br_taken,
  input logic [IMM_W-1:0] imm16,
  input logic [XLEN-1:0]  imm16_sx,
  input logic             is_add,
  input logic             is_sub,
  input logic             is_addi,
  input logic             is_blt,
  input logic             is_ldw,
  input logic             is_call,
  input logic             illegal,
  input logic [XLEN-1:0]  next_pc
);

  logic [6:0] flags;
  assign flags = {is_add, is_sub, is_addi, is_blt, is_ldw, is_call, illegal};

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (flags == '0 && next_pc == '0));

  p_one_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(flags) == 1);

  p_sext_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (imm16_sx[15:0] == imm16) &&
    (imm16_sx[31:16] == {16{imm16[15]}}));

  p_seq_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !is_call && !(is_blt && $past(br_taken)))
      |-> next_pc == $past(pc) + 32'd4);

  p_branch_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && is_blt && $past(br_taken))
      |-> next_pc == $past(pc) + 32'd4 +
                     {{16{$past(instr[21])}}, $past(instr[21:6])});

  p_call_region_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && is_call)
      |-> (next_pc[31:28] == $past(pc[31:28])) && (next_pc[1:0] == 2'b00));

endmodule

bind decode_stage decode_stage_chk u_decode_stage_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .instr    (instr),
  .pc       (pc),
  .br_taken (br_taken),
  .imm16    (imm16),
  .imm16_sx (imm16_sx),
  .is_add   (is_add),
  .is_sub   (is_sub),
  .is_addi  (is_addi),
  .is_blt   (is_blt),
  .is_ldw   (is_ldw),
  .is_call  (is_call),
  .illegal  (illegal),
  .next_pc  (next_pc)
);

// File: tb/test_decode_stage.sv
module test_decode_stage;

  localparam time CLK_PERIOD = 10ns;
  localparam int  N_RANDOM   = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic        br_taken = 1'b0;
  logic [4:0]  reg_a, reg_b, reg_c, shamt;
  logic [5:0]  ext_op, opcode;
  logic [15:0] imm16;
  logic [31:0] imm16_sx, next_pc;
  logic [25:0] imm26;
  logic        is_add, is_sub, is_addi, is_blt, is_ldw, is_call, illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decode_stage i_decode_stage (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .br_taken(br_taken),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .ext_op(ext_op),
    .shamt(shamt), .opcode(opcode), .imm16(imm16), .imm16_sx(imm16_sx),
    .imm26(imm26), .is_add(is_add), .is_sub(is_sub), .is_addi(is_addi),
    .is_blt(is_blt), .is_ldw(is_ldw), .is_call(is_call), .illegal(illegal),
    .next_pc(next_pc)
  );

  // Expected class vector {add,sub,addi,blt,ldw,call,illegal}
  function automatic logic [6:0] exp_flags(input logic [31:0] w);
    logic [5:0] o, x;
    o = w[5:0];
    x = w[16:11];
    if (o == 6'h3A && x == 6'h31) return 7'b1000000;
    if (o == 6'h3A && x == 6'h39) return 7'b0100000;
    case (o)
      6'h04:   return 7'b0010000;
      6'h16:   return 7'b0001000;
      6'h17:   return 7'b0000100;
      6'h00:   return 7'b0000010;
      default: return 7'b0000001;
    endcase
  endfunction

  function automatic logic [31:0] exp_npc(input logic [31:0] w,
                                          input logic [31:0] a,
                                          input logic t);
    logic signed [31:0] d;
    d = 32'(signed'(w[21:6]));
    if (w[5:0] == 6'h00)        return {a[31:28], w[31:6], 2'b00};
    if (w[5:0] == 6'h16 && t)   return a + 32'd4 + d;
    return a + 32'd4;
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] a,
                       input logic t);
    logic [31:0] fld_exp;
    @(negedge clk);
    instr = w; pc = a; br_taken = t;
    @(negedge clk);
    check("R2 fields", {reg_a, reg_b, reg_c, ext_op, shamt, opcode},
          {w[31:27], w[26:22], w[21:17], w[16:11], w[10:6], w[5:0]});
    fld_exp = {w[21:6], w[31:16]};
    check("R2 imm", {imm16, imm16_sx[31:16], 6'h0, imm26},
          {fld_exp[31:16], {16{w[21]}}, 6'h0, w[31:6]});
    check("R3 sext", imm16_sx, {{16{w[21]}}, w[21:6]});
    check("R4 R5 R6 class",
          {is_add, is_sub, is_addi, is_blt, is_ldw, is_call, illegal},
          exp_flags(w));
    check("R7 R8 R9 next_pc", next_pc, exp_npc(w, a, t));
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    w = $urandom;
    case ($urandom_range(0, 7))
      0: w[5:0] = 6'h04;
      1: w[5:0] = 6'h16;
      2: w[5:0] = 6'h17;
      3: w[5:0] = 6'h00;
      4: begin w[5:0] = 6'h3A; w[16:11] = 6'h31; end
      5: begin w[5:0] = 6'h3A; w[16:11] = 6'h39; end
      6: w[5:0] = 6'h3A;
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    instr = 32'hFFFF_FFD6;
    pc    = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset flags",
          {is_add, is_sub, is_addi, is_blt, is_ldw, is_call, illegal}, 0);
    check("R1 reset npc", next_pc, 0);
    check("R1 reset fields", {reg_a, imm26, opcode}, 0);
    rst_n = 1'b1;

    // R4: add, sub, other ext_op
    apply({5'd1, 5'd2, 5'd3, 6'h31, 5'd0, 6'h3A}, 32'h100, 1'b1);
    apply({5'd4, 5'd5, 5'd6, 6'h39, 5'd7, 6'h3A}, 32'h104, 1'b0);
    apply({5'd4, 5'd5, 5'd6, 6'h30, 5'd7, 6'h3A}, 32'h108, 1'b0);
    // R5 and R10: addi / ldw with taken high behave sequentially
    apply({5'd3, 5'd7, 16'h1234, 6'h04}, 32'h200, 1'b1);
    apply({5'd9, 5'd8, 16'hFFF0, 6'h17}, 32'h204, 1'b1);
    // R8: negative displacement back to self, and most negative
    apply({5'd8, 5'd9, 16'hFFFC, 6'h16}, 32'h0000_1000, 1'b1);
    apply({5'd8, 5'd9, 16'h8000, 6'h16}, 32'h0000_0010, 1'b1);
    apply({5'd8, 5'd9, 16'h7FFC, 6'h16}, 32'hFFFF_FFF0, 1'b1);
    // R7: blt not taken
    apply({5'd8, 5'd9, 16'h0040, 6'h16}, 32'h0000_3000, 1'b0);
    // R7: sequential wrap at top of space, illegal opcode
    apply(32'h0000_003F, 32'hFFFF_FFFC, 1'b1);
    // R9: call with region bits set, all-ones target
    apply({26'h3FF_FFFF, 6'h00}, 32'hF000_0000, 1'b0);
    apply({26'h000_0001, 6'h00}, 32'hA7FF_FFFC, 1'b1);

    for (int i = 0; i < N_RANDOM; i++)
      apply(rand_word(), {$urandom} & 32'hFFFF_FFFC, 1'($urandom));

    // R1: reset again clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset re-entry", {next_pc, 25'h0,
          is_add, is_sub, is_addi, is_blt, is_ldw, is_call, illegal}, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule